// File: doc/BRIEF.md
# PCI Bus Event Performance Counters

This block watches the control handshake of a PCI bus and keeps two independent counters of selected bus events. Each counter is steered by its own event selector and its own bus-owner filter; counter 1 also has a width filter that can instead switch on a direction filter. Counter 2 always applies its direction filter. A clock adds one to a counter only when the chosen event holds and every active qualifier matches in that same clock.

A two-bit mode field, shared by both counters, decides what happens at the top of the count range. A counter can saturate with a sticky flag, wrap and raise a held interrupt, wrap and emit a one-clock event pulse, or wrap and request error injection. Software loads either counter through a plain write port. The bus signals arrive already converted to active-high form. The sideband qualifiers come from the surrounding bus interface.

Top module: `pci_evt_counters`

## Requirements
- R1: While reset is asserted and in the first clock after it, both counts, the overflow flags, `irq`, `evt_pulse` and `err_inject` are 0.
- R2: The event code (ctl[3:0] for counter 1, ctl[11:8] for counter 2) selects the event. The codes are:
  - 1: every clock
  - 2: frame|irdy|trdy
  - 3: (irdy|trdy)&devsel
  - 4: irdy&trdy
  - 5: irdy&!trdy&devsel&stop
  - 6: frame now and not in the previous clock
  - 7: irdy&trdy&devsel&stop
  A qualifying clock raises the count by one at the next edge.
- R3: The owner code (ctl[7:4] for counter 1, ctl[15:12] for counter 2) filters by owner. The codes are:
  - 0: any owner
  - 1: neither loc_master nor loc_target
  - 2: loc_master or loc_target
  - 3: loc_master
  - 4: loc_target
  - 5: loc_target with tgt_mem=0
  - 6: loc_target with tgt_mem=1
- R4: Counter 1 width code ctl[21:20] filters as follows:
  - 0: any width
  - 1: xfer_w64=0 only
  - 2: xfer_w64=1 only
  - 3: any width, but only when dir_out equals ctl[18]
- R5: Counter 2 counts only when dir_out equals ctl[19], whatever the width.
- R6: Event code 0 or 8-15, or owner code 7-15, leaves that counter unchanged.
- R7: In mode 0 (ctl[17:16]=0), a counter holds at all-ones. The increment that brings it to all-ones sets its `ovf` bit. That bit stays set until a write to that counter clears it.
- R8: In mode 1, a counter wrapping from all-ones to 0 sets `irq` at the same edge. `irq` stays high until a clock with `irq_clr` high and no new wrap.
- R9: In mode 2, `evt_pulse` is high for exactly the clock after an edge where a counter wrapped to 0.
- R10: In mode 3, `err_inject` is high for exactly the clock after an edge where a counter wrapped to 0.
- R11: With `wr_en[i]` high, counter i takes `wr_data` at the next edge, whatever the event. This counts as no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl | input | 22 | Control word |
| bus_frame | input | 1 | FRAME, active high |
| bus_irdy | input | 1 | IRDY, active high |
| bus_trdy | input | 1 | TRDY, active high |
| bus_devsel | input | 1 | DEVSEL, active high |
| bus_stop | input | 1 | STOP, active high |
| loc_master | input | 1 | Local device owns the bus as master |
| loc_target | input | 1 | Local device is the addressed target |
| tgt_mem | input | 1 | Target access is to memory (1) or registers (0) |
| xfer_w64 | input | 1 | Transfer is 64 bits wide (1) or 32 (0) |
| dir_out | input | 1 | Data leaves the device (1) or enters it (0) |
| wr_en | input | 2 | Per-counter load strobe, bit 0 for counter 1 |
| wr_data | input | 32 | Load value |
| irq_clr | input | 1 | Clears the held interrupt |
| cnt1 | output | 32 | Counter 1 value |
| cnt2 | output | 32 | Counter 2 value |
| ovf | output | 2 | Sticky saturation flags, bit 0 for counter 1 |
| irq | output | 1 | Held wrap interrupt |
| evt_pulse | output | 1 | One-clock wrap event |
| err_inject | output | 1 | One-clock error-injection request |

## Verification
Two collisions matter here. The first is a load arriving on the same edge as a qualifying event, including when the counter sits at all-ones. The second is `irq_clr` arriving on the same edge as a fresh wrap. The bench preloads counters a few counts below all-ones and keeps the every-clock event selected. It then raises `wr_en` and `irq_clr` at random against the resulting wraps. A bench model applies "load wins" and "set wins" every cycle. The loaded value must show up with no wrap side effect, and a wrap that meets a clear must leave `irq` high.

// File: rtl/pci_evt_counters.sv
module pci_evt_counters #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [21:0]   ctl,
  input  logic          bus_frame,
  input  logic          bus_irdy,
  input  logic          bus_trdy,
  input  logic          bus_devsel,
  input  logic          bus_stop,
  input  logic          loc_master,
  input  logic          loc_target,
  input  logic          tgt_mem,
  input  logic          xfer_w64,
  input  logic          dir_out,
  input  logic [1:0]    wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          irq_clr,
  output logic [CW-1:0] cnt1,
  output logic [CW-1:0] cnt2,
  output logic [1:0]    ovf,
  output logic          irq,
  output logic          evt_pulse,
  output logic          err_inject
);
  localparam logic [CW-1:0] ALL1 = '1;
  localparam logic [CW-1:0] NEAR = {{(CW-1){1'b1}}, 1'b0};

  logic          frame_q;
  logic [CW-1:0] cnt [2];
  logic [3:0]    evc [2];
  logic [3:0]    owc [2];
  logic [1:0]    ev_ok, own_ok, qual_ok, hit, wrap;
  logic [1:0]    mode;

  assign mode   = ctl[17:16];
  assign evc[0] = ctl[3:0];
  assign evc[1] = ctl[11:8];
  assign owc[0] = ctl[7:4];
  assign owc[1] = ctl[15:12];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      case (evc[i])
        4'd1:    ev_ok[i] = 1'b1;
        4'd2:    ev_ok[i] = bus_frame | bus_irdy | bus_trdy;
        4'd3:    ev_ok[i] = (bus_irdy | bus_trdy) & bus_devsel;
        4'd4:    ev_ok[i] = bus_irdy & bus_trdy;
        4'd5:    ev_ok[i] = bus_irdy & ~bus_trdy & bus_devsel & bus_stop;
        4'd6:    ev_ok[i] = bus_frame & ~frame_q;
        4'd7:    ev_ok[i] = bus_irdy & bus_trdy & bus_devsel & bus_stop;
        default: ev_ok[i] = 1'b0;
      endcase
      case (owc[i])
        4'd0:    own_ok[i] = 1'b1;
        4'd1:    own_ok[i] = ~(loc_master | loc_target);
        4'd2:    own_ok[i] = loc_master | loc_target;
        4'd3:    own_ok[i] = loc_master;
        4'd4:    own_ok[i] = loc_target;
        4'd5:    own_ok[i] = loc_target & ~tgt_mem;
        4'd6:    own_ok[i] = loc_target & tgt_mem;
        default: own_ok[i] = 1'b0;
      endcase
    end
    case (ctl[21:20])
      2'd0:    qual_ok[0] = 1'b1;
      2'd1:    qual_ok[0] = ~xfer_w64;
      2'd2:    qual_ok[0] = xfer_w64;
      default: qual_ok[0] = (dir_out == ctl[18]);
    endcase
    qual_ok[1] = (dir_out == ctl[19]);
  end

  assign hit = ev_ok & own_ok & qual_ok;

  always_comb
    for (int i = 0; i < 2; i++)
      wrap[i] = hit[i] & ~wr_en[i] & (mode != 2'd0) & (cnt[i] == ALL1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q    <= 1'b0;
      cnt[0]     <= '0;
      cnt[1]     <= '0;
      ovf        <= '0;
      irq        <= 1'b0;
      evt_pulse  <= 1'b0;
      err_inject <= 1'b0;
    end else begin
      frame_q <= bus_frame;
      for (int i = 0; i < 2; i++) begin
        if (wr_en[i]) begin
          cnt[i] <= wr_data;
          ovf[i] <= 1'b0;
        end else if (hit[i]) begin
          if (mode != 2'd0) cnt[i] <= cnt[i] + 1'b1;
          else if (cnt[i] != ALL1) begin
            cnt[i] <= cnt[i] + 1'b1;
            if (cnt[i] == NEAR) ovf[i] <= 1'b1;
          end
        end
      end
      irq        <= ((mode == 2'd1) & |wrap) | (irq & ~irq_clr);
      evt_pulse  <= (mode == 2'd2) & |wrap;
      err_inject <= (mode == 2'd3) & |wrap;
    end
  end

  assign cnt1 = cnt[0];
  assign cnt2 = cnt[1];

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && cnt1 == ALL1 && !wr_en[0]) |=> (cnt1 == ALL1));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en[0] |=> (CW'(cnt1 - $past(cnt1)) <= CW'(1)));
  p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[3:0] == 4'd0 && !wr_en[0]) |=> $stable(cnt1));
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_pulse_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pulse) |-> ($past(mode) == 2'd2));
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_inject |-> (cnt1 == '0 || cnt2 == '0));
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[1] |=> (cnt2 == $past(wr_data)));
endmodule

// File: tb/pci_evt_counters_bench.sv
`timescale 1ns/1ps
module pci_evt_counters_bench;
  logic clk = 0, rst_n = 0;
  logic [21:0] ctl = '0;
  logic fr = 0, ir = 0, tr = 0, dv = 0, st = 0, lm = 0, lt = 0, mem = 0, w64 = 0, dout = 0, iclr = 0;
  logic [1:0] wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] cnt1, cnt2;
  logic [1:0] ovf;
  logic irq, evt_pulse, err_inject;
  int checks = 0, errors = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  pci_evt_counters u_pci_evt_counters (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .bus_frame(fr), .bus_irdy(ir), .bus_trdy(tr),
    .bus_devsel(dv), .bus_stop(st), .loc_master(lm), .loc_target(lt), .tgt_mem(mem),
    .xfer_w64(w64), .dir_out(dout), .wr_en(wr_en), .wr_data(wr_data), .irq_clr(iclr),
    .cnt1(cnt1), .cnt2(cnt2), .ovf(ovf), .irq(irq), .evt_pulse(evt_pulse), .err_inject(err_inject));

  logic [31:0] m1, m2;
  logic [1:0] mov;
  logic mirq, mevt, merr, mfq;

  function automatic logic ev_f(logic [3:0] c, logic fq);
    case (c)
      1: return 1;
      2: return fr || ir || tr;
      3: return (ir || tr) && dv;
      4: return ir && tr;
      5: return ir && !tr && dv && st;
      6: return fr && !fq;
      7: return ir && tr && dv && st;
      default: return 0;
    endcase
  endfunction

  function automatic logic own_f(logic [3:0] c);
    case (c)
      0: return 1;
      1: return !lm && !lt;
      2: return lm || lt;
      3: return lm;
      4: return lt;
      5: return lt && !mem;
      6: return lt && mem;
      default: return 0;
    endcase
  endfunction

  function automatic logic q1_f();
    case (ctl[21:20])
      0: return 1;
      1: return !w64;
      2: return w64;
      default: return dout == ctl[18];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; mov = 0; mirq = 0; mevt = 0; merr = 0; mfq = 0;
    end else begin
      logic h1, h2, wr1, wr2;
      logic [1:0] md;
      md = ctl[17:16];
      h1 = ev_f(ctl[3:0], mfq) && own_f(ctl[7:4]) && q1_f();
      h2 = ev_f(ctl[11:8], mfq) && own_f(ctl[15:12]) && (dout == ctl[19]);
      wr1 = !wr_en[0] && h1 && md != 0 && m1 == 32'hFFFF_FFFF;
      wr2 = !wr_en[1] && h2 && md != 0 && m2 == 32'hFFFF_FFFF;
      mirq = (md == 1 && (wr1 || wr2)) || (mirq && !iclr);
      mevt = md == 2 && (wr1 || wr2);
      merr = md == 3 && (wr1 || wr2);
      if (wr_en[0]) begin m1 = wr_data; mov[0] = 0; end
      else if (h1) begin
        if (md != 0) m1 = m1 + 1;
        else if (m1 != 32'hFFFF_FFFF) begin m1 = m1 + 1; if (m1 == 32'hFFFF_FFFF) mov[0] = 1; end
      end
      if (wr_en[1]) begin m2 = wr_data; mov[1] = 0; end
      else if (h2) begin
        if (md != 0) m2 = m2 + 1;
        else if (m2 != 32'hFFFF_FFFF) begin m2 = m2 + 1; if (m2 == 32'hFFFF_FFFF) mov[1] = 1; end
      end
      mfq = fr;
    end
  end

  task automatic compare();
    logic [68:0] got, exp;
    got = {cnt1, cnt2, ovf, irq, evt_pulse, err_inject};
    exp = {m1, m2, mov, mirq, mevt, merr};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got cnt1=%h cnt2=%h ovf=%b irq=%b evt=%b err=%b expected cnt1=%h cnt2=%h ovf=%b irq=%b evt=%b err=%b",
               tag, cnt1, cnt2, ovf, irq, evt_pulse, err_inject, m1, m2, mov, mirq, mevt, merr);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); compare();
  endtask

  task automatic rnd_bus(int wr_pct, int clr_pct);
    logic [31:0] r;
    r = $urandom;
    {fr, ir, tr, dv, st, lm, lt, mem, w64, dout} = r[9:0];
    iclr = ($urandom % 100) < clr_pct;
    wr_en = 0;
    if (($urandom % 100) < wr_pct) begin
      wr_en = 2'($urandom % 3 + 1);
      wr_data = ($urandom % 2) ? 32'hFFFF_FFFF - ($urandom % 6) : $urandom;
    end
  endtask

  task automatic run(int n, int wr_pct, int clr_pct);
    for (int k = 0; k < n; k++) begin rnd_bus(wr_pct, clr_pct); tick(); end
  endtask

  task automatic load(logic [31:0] v);
    wr_en = 2'b11; wr_data = v; tick(); wr_en = 0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    tick();
    tag = "R2";
    for (int c = 1; c < 8; c++) begin ctl = '0; ctl[3:0] = 4'(c); ctl[11:8] = 4'(8 - c); ctl[19] = 1'b1; ctl[17:16] = 2'd1; run(150, 0, 0); end
    tag = "R6";
    for (int c = 8; c < 16; c++) begin ctl = '0; ctl[3:0] = 4'(c); ctl[7:4] = 4'(c); ctl[11:8] = 4'd1; ctl[15:12] = 4'(c); run(20, 0, 0); end
    tag = "R3";
    for (int c = 0; c < 7; c++) begin ctl = '0; ctl[3:0] = 4'd4; ctl[7:4] = 4'(c); ctl[11:8] = 4'd2; ctl[15:12] = 4'(6 - c); run(150, 0, 0); end
    tag = "R4 R5";
    for (int c = 0; c < 8; c++) begin ctl = '0; ctl[3:0] = 4'd1; ctl[11:8] = 4'd1; ctl[21:20] = 2'(c % 4); ctl[18] = c[2]; ctl[19] = ~c[2]; run(150, 0, 0); end
    tag = "R7";
    ctl = '0; ctl[3:0] = 4'd1; ctl[11:8] = 4'd1;
    load(32'hFFFF_FFFC); run(8, 0, 0); load(32'h0000_0010); run(3, 0, 0);
    tag = "R8";
    ctl[17:16] = 2'd1; load(32'hFFFF_FFFE); run(6, 0, 0); iclr = 1; tick(); iclr = 0; run(3, 0, 0);
    load(32'hFFFF_FFFF); iclr = 1; tick(); iclr = 0; run(2, 0, 0);
    tag = "R9";
    ctl[17:16] = 2'd2; load(32'hFFFF_FFFD); run(6, 0, 0);
    tag = "R10";
    ctl[17:16] = 2'd3; load(32'hFFFF_FFFD); run(6, 0, 0);
    tag = "R11";
    ctl[17:16] = 2'd1; load(32'hFFFF_FFFF); wr_en = 2'b01; wr_data = 32'h5; tick(); wr_en = 0; run(2, 0, 0);
    for (int c = 0; c < 4; c++) begin ctl = '0; ctl[3:0] = 4'd1; ctl[11:8] = 4'd2; ctl[17:16] = 2'(c); run(600, 25, 20); end
    tag = "R2 R11";
    for (int k = 0; k < 20; k++) begin ctl = 22'($urandom); run(150, 15, 10); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule